// File: doc/BRIEF.md
# Flexible Trellis Traceback Unit

This block walks backwards through stored survivor decisions of a trellis decoder and produces one hard-decision bit per step. The constraint length is chosen at run time, anywhere from 3 to 9. One state-recursion rule serves every length. A software-loaded one-bit table supplies the output bits when the trellis belongs to a recursive (turbo constituent) code. For a plain feedforward code the output bit follows directly from the state arithmetic.

Each trellis step is stored as one row of a decision memory. Bit `s` of the row is the survivor decision of state `s`. A start request carries a start state, a start row address, a step count, the constraint length and the mode. The unit then reads one row per cycle, walking downwards through the addresses. It updates its current state from the selected decision bit and emits the decoded bits in reverse time order, each with a valid strobe. A done pulse accompanies the last bit.

Top module: `tbk_traceback`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `bit_valid`, `done` and `mem_rd_en` are low.
- R2: A start request made while idle issues `trace_len` consecutive memory reads, one per cycle, beginning in the cycle after the request. The first read is at `start_addr`, and each later address is one lower, wrapping modulo the memory depth.
- R3: With current state C and decision bit d = bit C of the row read, the next state is 2C+d-2^(K-1) if C ≥ 2^(K-2), and 2C+d otherwise. Each valid output presents that next state on `state_out`.
- R4: In feedforward mode (`turbo_mode`=0), the decoded bit is 1 when C ≥ 2^(K-2) and 0 otherwise.
- R5: In recursive mode (`turbo_mode`=1), the decoded bit is the table entry at index 2C+d. Table entry i is written with `tbl_we`, `tbl_waddr`=i and `tbl_wdata`.
- R6: The first decoded bit is valid two cycles after the first read. The bits then follow on consecutive cycles, `trace_len` of them in all. `done` pulses in the same cycle as the last bit.
- R7: A start request made while `busy` is high has no effect on reads, bits, states or `done`.
- R8: A `k_sel` below 3 acts as 3, and one above 9 acts as 9. The start state is reduced to its low K-1 bits.
- R9: A start request with `trace_len`=0 makes no reads and no valid bits. It pulses `done` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| start | input | 1 | Start request, taken only while idle |
| start_state | input | 8 | State the traceback begins from |
| start_addr | input | 6 | Decision row read first |
| trace_len | input | 7 | Number of steps to trace |
| k_sel | input | 4 | Constraint length, 3 to 9 |
| turbo_mode | input | 1 | 1 selects table-driven output bits |
| mem_rd_en | output | 1 | Decision memory read strobe |
| mem_addr | output | 6 | Decision memory row address |
| mem_row | input | 256 | Row returned one cycle after the read; bit s is the decision of state s |
| tbl_we | input | 1 | Decision table write enable |
| tbl_waddr | input | 9 | Decision table write index |
| tbl_wdata | input | 1 | Decision table write data |
| busy | output | 1 | Traceback in progress |
| bit_valid | output | 1 | Decoded bit strobe |
| bit_out | output | 1 | Decoded bit |
| state_out | output | 8 | Trellis state reached by the step just taken |
| done | output | 1 | Pulse with the last bit, or alone for a zero-length request |

## Verification
The unit is driven with start states on both sides of the 2^(K-2) boundary. These separate the subtracting branch of the recursion from the plain shift and show whether the feedforward output bit tracks that branch. The runs cover the smallest and largest lengths, several lengths in between, and out-of-range `k_sel` values. Mistakes in half-state and full-state scaling show up as state mismatches. Recursive-mode runs over the same pseudo-random decision rows show whether the table is indexed with the decision bit appended. Start addresses close to zero expose address wrap. A start request made mid-run and a zero-length request check that the step counting does not pick up stray requests.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

  typedef enum logic {
    TB_IDLE = 1'b0,
    TB_RUN  = 1'b1
  } tb_fsm_e;

  // Bring a requested constraint length into the supported range.
  function automatic logic [3:0] clamp_k(input logic [3:0] ks, input int kmax);
    logic [3:0] r;
    if (ks < 4'd3)             r = 4'd3;
    else if (ks > 4'(kmax))    r = 4'(kmax);
    else                       r = ks;
    return r;
  endfunction

endpackage

// File: rtl/tbk_dec_table.sv
module tbk_dec_table #(
  parameter  int K_MAX = 9,
  localparam int N_ENT = 1 << K_MAX
) (
  input  logic             clk,
  input  logic             we,
  input  logic [K_MAX-1:0] waddr,
  input  logic             wdata,
  input  logic [K_MAX-1:0] raddr,
  output logic             rdata
);

  logic ent_q [N_ENT];

  // Storage holds no reset: it is loaded before use.
  always_ff @(posedge clk) begin
    if (we) begin
      ent_q[waddr] <= wdata;
    end
  end

  assign rdata = ent_q[raddr];

endmodule

// File: rtl/tbk_state_step.sv
module tbk_state_step #(
  parameter  int K_MAX = 9,
  localparam int ST_W  = K_MAX - 1
) (
  input  logic [ST_W-1:0]  cur,
  input  logic             decbit,
  input  logic [3:0]       k,
  output logic [ST_W-1:0]  prev,
  output logic             upper,
  output logic [K_MAX-1:0] ext_idx
);

  logic [K_MAX-1:0] ext;
  logic [K_MAX-1:0] half_st;
  logic [K_MAX-1:0] full_st;
  logic [K_MAX-1:0] diff;

  always_comb begin
    ext     = {cur, decbit};
    half_st = K_MAX'(1) << (k - 4'd2);
    full_st = K_MAX'(1) << (k - 4'd1);
    diff    = ext - full_st;
    upper   = ({1'b0, cur} >= half_st);
    prev    = upper ? diff[ST_W-1:0] : ext[ST_W-1:0];
    ext_idx = ext;
  end

endmodule

// File: rtl/tbk_ctrl.sv
module tbk_ctrl
  import tbk_pkg::*;
#(
  parameter int DEPTH_W = 6,
  parameter int LEN_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DEPTH_W-1:0] start_addr,
  input  logic [LEN_W-1:0]   trace_len,
  output logic               load,
  output logic               busy,
  output logic               rd_en,
  output logic [DEPTH_W-1:0] rd_addr,
  output logic               step,
  output logic               done
);

  tb_fsm_e            fsm_q, fsm_d;
  logic [DEPTH_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]   issue_q, issue_d;
  logic [LEN_W-1:0]   remain_q, remain_d;
  logic               pend_q, pend_d;
  logic               done_q, done_d;

  always_comb begin
    fsm_d    = fsm_q;
    addr_d   = addr_q;
    issue_d  = issue_q;
    remain_d = remain_q;
    done_d   = 1'b0;
    load     = start && (fsm_q == TB_IDLE);
    rd_en    = (fsm_q == TB_RUN) && (issue_q != '0);
    pend_d   = rd_en;

    if (load) begin
      if (trace_len == '0) begin
        done_d = 1'b1;
      end else begin
        fsm_d    = TB_RUN;
        addr_d   = start_addr;
        issue_d  = trace_len;
        remain_d = trace_len;
      end
    end

    if (rd_en) begin
      addr_d  = addr_q - 1'b1;
      issue_d = issue_q - 1'b1;
    end

    if (pend_q) begin
      remain_d = remain_q - 1'b1;
      if (remain_q == LEN_W'(1)) begin
        fsm_d  = TB_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q    <= TB_IDLE;
      addr_q   <= '0;
      issue_q  <= '0;
      remain_q <= '0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      fsm_q    <= fsm_d;
      addr_q   <= addr_d;
      issue_q  <= issue_d;
      remain_q <= remain_d;
      pend_q   <= pend_d;
      done_q   <= done_d;
    end
  end

  assign busy    = (fsm_q == TB_RUN);
  assign rd_addr = addr_q;
  assign step    = pend_q;
  assign done    = done_q;

endmodule

// File: rtl/tbk_traceback.sv
module tbk_traceback
  import tbk_pkg::*;
#(
  parameter  int K_MAX   = 9,
  parameter  int DEPTH_W = 6,
  parameter  int LEN_W   = 7,
  localparam int ST_W    = K_MAX - 1,
  localparam int ROW_W   = 1 << ST_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ST_W-1:0]    start_state,
  input  logic [DEPTH_W-1:0] start_addr,
  input  logic [LEN_W-1:0]   trace_len,
  input  logic [3:0]         k_sel,
  input  logic               turbo_mode,
  output logic               mem_rd_en,
  output logic [DEPTH_W-1:0] mem_addr,
  input  logic [ROW_W-1:0]   mem_row,
  input  logic               tbl_we,
  input  logic [K_MAX-1:0]   tbl_waddr,
  input  logic               tbl_wdata,
  output logic               busy,
  output logic               bit_valid,
  output logic               bit_out,
  output logic [ST_W-1:0]    state_out,
  output logic               done
);

  logic             load;
  logic             step;
  logic [3:0]       k_eff;
  logic [ST_W-1:0]  st_mask;

  logic [3:0]       k_q, k_d;
  logic             mode_q, mode_d;
  logic [ST_W-1:0]  cur_q, cur_d;
  logic             bit_q, bit_d;
  logic [ST_W-1:0]  sout_q, sout_d;
  logic             vld_q, vld_d;

  logic             decbit;
  logic [ST_W-1:0]  prev;
  logic             upper;
  logic [K_MAX-1:0] tbl_idx;
  logic             tbl_bit;

  tbk_ctrl #(
    .DEPTH_W (DEPTH_W),
    .LEN_W   (LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .trace_len  (trace_len),
    .load       (load),
    .busy       (busy),
    .rd_en      (mem_rd_en),
    .rd_addr    (mem_addr),
    .step       (step),
    .done       (done)
  );

  assign decbit = mem_row[cur_q];

  tbk_state_step #(
    .K_MAX (K_MAX)
  ) u_step (
    .cur     (cur_q),
    .decbit  (decbit),
    .k       (k_q),
    .prev    (prev),
    .upper   (upper),
    .ext_idx (tbl_idx)
  );

  tbk_dec_table #(
    .K_MAX (K_MAX)
  ) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (tbl_idx),
    .rdata (tbl_bit)
  );

  assign k_eff   = clamp_k(k_sel, K_MAX);
  assign st_mask = (ST_W'(1) << (k_eff - 4'd1)) - 1'b1;

  always_comb begin
    k_d    = k_q;
    mode_d = mode_q;
    cur_d  = cur_q;
    bit_d  = bit_q;
    sout_d = sout_q;
    vld_d  = 1'b0;
    if (load) begin
      k_d    = k_eff;
      mode_d = turbo_mode;
      cur_d  = start_state & st_mask;
    end
    if (step) begin
      cur_d  = prev;
      bit_d  = mode_q ? tbl_bit : upper;
      sout_d = prev;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= 4'(K_MAX);
      mode_q <= 1'b0;
      cur_q  <= '0;
      bit_q  <= 1'b0;
      sout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      k_q    <= k_d;
      mode_q <= mode_d;
      cur_q  <= cur_d;
      bit_q  <= bit_d;
      sout_q <= sout_d;
      vld_q  <= vld_d;
    end
  end

  assign bit_valid = vld_q;
  assign bit_out   = bit_q;
  assign state_out = sout_q;

endmodule

// File: rtl/tbk_checker.sv
module tbk_checker #(
  parameter  int K_MAX   = 9,
  parameter  int DEPTH_W = 6,
  localparam int ST_W    = K_MAX - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               mem_rd_en,
  input logic [DEPTH_W-1:0] mem_addr,
  input logic               bit_valid,
  input logic               bit_out,
  input logic [ST_W-1:0]    state_out,
  input logic               done,
  input logic [3:0]         k_q,
  input logic               mode_q
);

  logic [ST_W:0] half_c;
  assign half_c = (ST_W+1)'(1) << (k_q - 4'd2);

  // R2
  addr_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == DEPTH_W'($past(mem_addr) - 1'b1)));

  // R2
  read_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  // R6
  read_to_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ##2 bit_valid);

  // R6
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> (bit_valid && !busy));

  // R3
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (({1'b0, state_out} >> (k_q - 4'd1)) == '0));

  // R4
  ff_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && $past(bit_valid) && !mode_q) |->
      ((({1'b0, state_out} >> 1) == ({1'b0, $past(state_out)} & (half_c - 1'b1))) &&
       (bit_out == ({1'b0, $past(state_out)} >= half_c))));

endmodule

bind tbk_traceback tbk_checker #(
  .K_MAX   (K_MAX),
  .DEPTH_W (DEPTH_W)
) u_tbk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr),
  .bit_valid (bit_valid),
  .bit_out   (bit_out),
  .state_out (state_out),
  .done      (done),
  .k_q       (k_q),
  .mode_q    (mode_q)
);

// File: tb/tb_tbk_traceback.sv
module tb_tbk_traceback;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [7:0]   start_state;
  logic [5:0]   start_addr;
  logic [6:0]   trace_len;
  logic [3:0]   k_sel;
  logic         turbo_mode;
  logic         mem_rd_en;
  logic [5:0]   mem_addr;
  logic [255:0] mem_row;
  logic         tbl_we;
  logic [8:0]   tbl_waddr;
  logic         tbl_wdata;
  logic         busy;
  logic         bit_valid;
  logic         bit_out;
  logic [7:0]   state_out;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [255:0] mem [64];

  tbk_traceback dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_state(start_state),
    .start_addr(start_addr), .trace_len(trace_len), .k_sel(k_sel),
    .turbo_mode(turbo_mode), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_row(mem_row), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .busy(busy), .bit_valid(bit_valid),
    .bit_out(bit_out), .state_out(state_out), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Decision memory model: one cycle read latency.
  always @(posedge clk) begin
    if (mem_rd_en) mem_row <= mem[mem_addr];
  end

  function automatic logic memb(int a, int s);
    int v;
    v = a * 97 + s * 31 + ((a * s) >> 3);
    return v[2] ^ v[5];
  endfunction

  function automatic logic tblv(int i);
    int v;
    v = i * 53 + 17;
    return v[3] ^ v[1] ^ i[0];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_trace(input int ks, input logic md, input int st, input int sa,
                           input int ln, input string tag, input int poke);
    int k, c, a, d, idx, p;
    int eb [128];
    int es [128];
    int done_cyc;
    string btag;
    k = (ks < 3) ? 3 : ((ks > 9) ? 9 : ks);
    c = st & ((1 << (k - 1)) - 1);
    a = sa;
    for (int i = 0; i < ln; i++) begin
      d   = int'(memb(a, c));
      idx = 2 * c + d;
      if (c >= (1 << (k - 2))) begin
        p = idx - (1 << (k - 1));
        eb[i] = md ? int'(tblv(idx)) : 1;
      end else begin
        p = idx;
        eb[i] = md ? int'(tblv(idx)) : 0;
      end
      es[i] = p;
      c = p;
      a = (a - 1) & 63;
    end
    done_cyc = (ln == 0) ? 1 : ln + 2;
    btag = md ? "R5 table bit" : "R4 feedforward bit";

    @(negedge clk);
    k_sel       = ks[3:0];
    turbo_mode  = md;
    start_state = st[7:0];
    start_addr  = sa[5:0];
    trace_len   = ln[6:0];
    start       = 1'b1;

    for (int cyc = 1; cyc <= ln + 4; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      chk(mem_rd_en == (cyc <= ln), {"R2 read enable ", tag}, int'(mem_rd_en), int'(cyc <= ln));
      if (cyc <= ln) begin
        chk(int'(mem_addr) == ((sa - (cyc - 1)) & 63), {"R2 address ", tag},
            int'(mem_addr), (sa - (cyc - 1)) & 63);
      end
      chk(bit_valid == (cyc >= 3 && cyc <= ln + 2), {"R6 valid ", tag},
          int'(bit_valid), int'(cyc >= 3 && cyc <= ln + 2));
      chk(done == (cyc == done_cyc), {(ln == 0) ? "R9 done " : "R6 done ", tag},
          int'(done), int'(cyc == done_cyc));
      if (bit_valid && cyc >= 3 && cyc <= ln + 2) begin
        chk(int'(bit_out) == eb[cyc - 3], {btag, " ", tag}, int'(bit_out), eb[cyc - 3]);
        chk(int'(state_out) == es[cyc - 3], {"R3 state ", tag}, int'(state_out), es[cyc - 3]);
      end
      if (poke != 0 && cyc == poke) begin
        start       = 1'b1;
        k_sel       = 4'd4;
        turbo_mode  = ~md;
        start_state = 8'h01;
        start_addr  = 6'd7;
        trace_len   = 7'd3;
      end
    end
  endtask

  typedef struct packed {
    logic [3:0] k;
    logic       md;
    logic [7:0] st;
    logic [5:0] sa;
    logic [6:0] ln;
    logic       r8;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b0, 8'd3,   6'd10, 7'd8,  1'b0},
    '{4'd9,  1'b0, 8'd200, 6'd63, 7'd20, 1'b0},
    '{4'd7,  1'b0, 8'h55,  6'd5,  7'd12, 1'b0},
    '{4'd4,  1'b1, 8'd5,   6'd30, 7'd10, 1'b0},
    '{4'd9,  1'b1, 8'd255, 6'd2,  7'd9,  1'b0},
    '{4'd2,  1'b0, 8'hFF,  6'd40, 7'd6,  1'b1},
    '{4'd15, 1'b1, 8'd17,  6'd50, 7'd7,  1'b1},
    '{4'd5,  1'b0, 8'hF0,  6'd20, 7'd1,  1'b1},
    '{4'd8,  1'b1, 8'd100, 6'd0,  7'd5,  1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 256; s++)
        mem[a][s] = memb(a, s);
    rst_n = 1'b0; start = 1'b0; start_state = '0; start_addr = '0;
    trace_len = '0; k_sel = 4'd3; turbo_mode = 1'b0;
    tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !bit_valid && !done && !mem_rd_en, "R1 in reset", int'({busy, bit_valid, done, mem_rd_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    chk(!busy && !bit_valid && !done && !mem_rd_en, "R1 after reset", int'({busy, bit_valid, done, mem_rd_en}), 0);

    for (int i = 0; i < 512; i++) begin
      tbl_we = 1'b1; tbl_waddr = i[8:0]; tbl_wdata = tblv(i);
      @(negedge clk);
    end
    tbl_we = 1'b0;

    for (int v = 0; v < NV; v++) begin
      run_trace(int'(VECS[v].k), VECS[v].md, int'(VECS[v].st), int'(VECS[v].sa),
                int'(VECS[v].ln), VECS[v].r8 ? "R8 clamp/mask" : "table", 0);
    end

    // R7: request in the middle of a run, and one in the cycle done is raised
    run_trace(6, 1'b0, 9, 33, 10, "R7 mid-run start", 3);
    run_trace(9, 1'b1, 131, 1, 4, "R7 late start", 5);
    // R9: zero length
    run_trace(7, 1'b0, 12, 15, 0, "R9 zero length", 0);
    // longest run, wrapping the whole memory
    run_trace(9, 1'b0, 77, 3, 127, "R2 long wrap", 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule